// File: doc/BRIEF.md
# Bidirectional Reset Pin Sequencer

This block produces the internal reset of a device from three requests: an external active-low reset pin, a watchdog timeout and a software reset request. Each request starts an internal reset sequence. The sequence stays active while any request is present and then for a fixed number of clock cycles. The shared reset pin is open-drain. While a sequence is running, the block can pull that pin low so that other devices on the board see resets that began inside the chip. The pad is not part of the block: the pin reaches it as a level input, and it leaves as a drive-low enable.

A configuration bit, written by software while no reset is in progress, chooses whether watchdog and software resets appear on the pin. Every reset sequence clears this bit, so after any reset internal resets stay off the pin until software sets the bit again. A reset that an external low level starts always drives the pin for the rest of its sequence. The pin level passes through a synchroniser before use. The block cannot tell its own drive apart from an external low, so it ignores the pin while it drives and for a short guard window afterwards. A 2-bit cause register records what started the most recent reset.

Top module: `rstpin_ctrl`

## Requirements
- R1: While `por` is high, `core_rst` is 1, `rst_pin_oe` is 0 and `rst_cause` is 0 (power-on). After `por` falls, `core_rst` stays high for STRETCH_CYCLES more cycles and then falls.
- R2: A high watchdog or software request, sampled at a clock edge while no sequence runs, makes `core_rst` high from that edge on.
- R3: `core_rst` stays high while any request is sampled high, and it falls exactly STRETCH_CYCLES cycles after the last edge at which a request was sampled high.
- R4: When the enable bit is 1 at the start of a watchdog or software reset, `rst_pin_oe` is 1 from the first cycle of the sequence until the stretch count runs out.
- R5: When the enable bit is 0, watchdog and software resets assert `core_rst` but never `rst_pin_oe`.
- R6: Every reset sequence clears the enable bit, and a write to it while `core_rst` is high has no effect. A later watchdog or software reset therefore does not drive the pin unless software writes the bit again.
- R7: A low level on `rst_pin_in` that lasts SYNC_STAGES clock edges starts a sequence one edge later. This sequence asserts both `core_rst` and `rst_pin_oe`, whatever the enable bit holds, and sets `rst_cause` to 1.
- R8: After the block releases the pin, `core_rst` stays high for SYNC_STAGES+1 guard cycles during which the pin is ignored. If the pin then reads high, the sequence ends. If it still reads low, the drive resumes and `core_rst` shows no gap.
- R9: `rst_cause` is loaded only when a sequence starts from idle, with the codes 1 external, 2 watchdog and 3 software. The priority is external, then watchdog, then software. The value holds until the next sequence starts.
- R10: `rst_pin_oe` is never 1 while `core_rst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst_pin_in | input | 1 | Level seen on the reset pad, low means reset |
| wdog_trip | input | 1 | Watchdog timeout request, level |
| sw_rst_req | input | 1 | Software reset request, level |
| cfg_wr | input | 1 | Write strobe for the pin-signalling enable bit |
| cfg_bidir_en | input | 1 | Value written to the enable bit |
| rst_pin_oe | output | 1 | Drive the reset pad low |
| core_rst | output | 1 | Internal reset, active high |
| rst_cause | output | 2 | Source of the last reset (0 power-on, 1 pin, 2 watchdog, 3 software) |

## Verification
The case that is hardest to reach from the ports is the end of the guard window while an outside agent still holds the pin low. The block's own drive hides that low level until the synchroniser has flushed. The bench models the open-drain wire as the AND of its own pull-down and the block's output enable. It holds the external low across the whole first sequence and checks that the drive comes back on the exact edge at which the guard expires, with `core_rst` still high. A second pass releases the pin early and expects the sequence to end at that same edge.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;

    typedef enum logic [1:0] {
        CAUSE_POWERON  = 2'd0,
        CAUSE_EXTPIN   = 2'd1,
        CAUSE_WATCHDOG = 2'd2,
        CAUSE_SOFTWARE = 2'd3
    } rst_cause_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_HOLD  = 2'd1,
        SEQ_GUARD = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic ext;
        logic wdt;
        logic sw;
    } rst_req_t;

    // Priority: pin first, then watchdog, then software
    function automatic rst_cause_e pick_cause(rst_req_t r);
        if (r.ext)      return CAUSE_EXTPIN;
        else if (r.wdt) return CAUSE_WATCHDOG;
        else if (r.sw)  return CAUSE_SOFTWARE;
        else            return CAUSE_POWERON;
    endfunction

    function automatic logic any_req(rst_req_t r);
        return r.ext | r.wdt | r.sw;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic por,
    input  logic pad_lvl,
    output logic lvl_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (por) chain <= '1;
                else     chain <= pad_lvl;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (por) chain <= '1;
                else     chain <= {chain[STAGES-2:0], pad_lvl};
            end
        end
    endgenerate

    assign lvl_sync = chain[STAGES-1];
endmodule

// File: rtl/rstpin_src.sv
module rstpin_src
    import rstpin_pkg::*;
(
    input  logic     pin_sync,
    input  logic     own_drive_mask,
    input  logic     wdog_trip,
    input  logic     sw_rst_req,
    output rst_req_t req
);
    // A low pin counts as a request only when the block's own drive cannot explain it
    always_comb begin
        req.ext = ~pin_sync & ~own_drive_mask;
        req.wdt = wdog_trip;
        req.sw  = sw_rst_req;
    end
endmodule

// File: rtl/rstpin_cfg.sv
module rstpin_cfg (
    input  logic clk,
    input  logic por,
    input  logic seq_idle,
    input  logic wr,
    input  logic wdata,
    output logic bidir_en
);
    always_ff @(posedge clk) begin
        if (por || !seq_idle) bidir_en <= 1'b0;
        else if (wr)          bidir_en <= wdata;
    end
endmodule

// File: rtl/rstpin_seq.sv
module rstpin_seq
    import rstpin_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 16,
    parameter int unsigned GUARD_CYCLES   = 3
) (
    input  logic       clk,
    input  logic       por,
    input  rst_req_t   req,
    input  logic       bidir_en,
    output logic       core_rst,
    output logic       pin_oe,
    output rst_cause_e cause,
    output logic       own_drive_mask,
    output logic       seq_idle
);
    localparam int unsigned CNT_MAX = (STRETCH_CYCLES > GUARD_CYCLES) ? STRETCH_CYCLES : GUARD_CYCLES;
    localparam int unsigned CW      = cnt_width(CNT_MAX);
    localparam logic [CW-1:0] HOLD_LD  = CW'(STRETCH_CYCLES - 1);
    localparam logic [CW-1:0] GUARD_LD = CW'(GUARD_CYCLES - 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic          drive_sel;
    logic          req_any;

    assign req_any = any_req(req);

    always_ff @(posedge clk) begin
        if (por) begin
            state     <= SEQ_HOLD;
            cnt       <= HOLD_LD;
            drive_sel <= 1'b0;
            cause     <= CAUSE_POWERON;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (req_any) begin
                        state     <= SEQ_HOLD;
                        cnt       <= HOLD_LD;
                        drive_sel <= req.ext | bidir_en;
                        cause     <= pick_cause(req);
                    end
                end
                SEQ_HOLD: begin
                    if (req_any) begin
                        cnt <= HOLD_LD;
                    end else if (cnt == '0) begin
                        state <= drive_sel ? SEQ_GUARD : SEQ_IDLE;
                        cnt   <= GUARD_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEQ_GUARD: begin
                    if (req_any) begin
                        state     <= SEQ_HOLD;
                        cnt       <= HOLD_LD;
                        drive_sel <= req.ext | bidir_en;
                    end else if (cnt == '0) begin
                        state <= SEQ_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign seq_idle       = (state == SEQ_IDLE);
    assign core_rst       = !seq_idle;
    assign pin_oe         = (state == SEQ_HOLD) && drive_sel;
    assign own_drive_mask = pin_oe || ((state == SEQ_GUARD) && (cnt != '0));
endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl
    import rstpin_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 16,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       por,
    input  logic       rst_pin_in,
    input  logic       wdog_trip,
    input  logic       sw_rst_req,
    input  logic       cfg_wr,
    input  logic       cfg_bidir_en,
    output logic       rst_pin_oe,
    output logic       core_rst,
    output logic [1:0] rst_cause
);
    localparam int unsigned GUARD_CYCLES = SYNC_STAGES + 1;

    logic       pin_sync;
    logic       own_mask;
    logic       seq_idle;
    logic       en_q;
    rst_req_t   req;
    rst_cause_e cause_q;

    rstpin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .por      (por),
        .pad_lvl  (rst_pin_in),
        .lvl_sync (pin_sync)
    );

    rstpin_src src_i (
        .pin_sync       (pin_sync),
        .own_drive_mask (own_mask),
        .wdog_trip      (wdog_trip),
        .sw_rst_req     (sw_rst_req),
        .req            (req)
    );

    rstpin_cfg cfg_i (
        .clk      (clk),
        .por      (por),
        .seq_idle (seq_idle),
        .wr       (cfg_wr),
        .wdata    (cfg_bidir_en),
        .bidir_en (en_q)
    );

    rstpin_seq #(
        .STRETCH_CYCLES (STRETCH_CYCLES),
        .GUARD_CYCLES   (GUARD_CYCLES)
    ) seq_i (
        .clk            (clk),
        .por            (por),
        .req            (req),
        .bidir_en       (en_q),
        .core_rst       (core_rst),
        .pin_oe         (rst_pin_oe),
        .cause          (cause_q),
        .own_drive_mask (own_mask),
        .seq_idle       (seq_idle)
    );

    assign rst_cause = cause_q;
endmodule

// File: rtl/rstpin_ctrl_chk.sv
module rstpin_ctrl_chk (
    input logic       clk,
    input logic       por,
    input logic       wdog_trip,
    input logic       sw_rst_req,
    input logic       rst_pin_oe,
    input logic       core_rst,
    input logic [1:0] rst_cause
);
    assert_por_state_R1: assert property (@(posedge clk)
        por |=> (core_rst && !rst_pin_oe && rst_cause == 2'd0));

    assert_request_starts_R2: assert property (@(posedge clk) disable iff (por)
        (wdog_trip || sw_rst_req) |=> core_rst);

    assert_no_early_release_R3: assert property (@(posedge clk) disable iff (por)
        $fell(core_rst) |-> (!$past(wdog_trip) && !$past(sw_rst_req)));

    assert_guard_after_drive_R8: assert property (@(posedge clk) disable iff (por)
        $fell(rst_pin_oe) |-> core_rst);

    assert_cause_holds_R9: assert property (@(posedge clk) disable iff (por)
        !$rose(core_rst) |-> $stable(rst_cause));

    assert_drive_needs_rst_R10: assert property (@(posedge clk) disable iff (por)
        rst_pin_oe |-> core_rst);
endmodule

bind rstpin_ctrl rstpin_ctrl_chk chk_i (
    .clk        (clk),
    .por        (por),
    .wdog_trip  (wdog_trip),
    .sw_rst_req (sw_rst_req),
    .rst_pin_oe (rst_pin_oe),
    .core_rst   (core_rst),
    .rst_cause  (rst_cause)
);

// File: tb/rstpin_ctrl_tb_top.sv
module rstpin_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned N = 6;   // stretch cycles
    localparam int unsigned S = 2;   // sync stages
    localparam int unsigned G = S + 1;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic ext_low = 1'b0;
    logic wdog_trip = 1'b0;
    logic sw_rst_req = 1'b0;
    logic cfg_wr = 1'b0;
    logic cfg_bidir_en = 1'b0;
    logic rst_pin_oe;
    logic core_rst;
    logic [1:0] rst_cause;
    logic rst_pin_in;

    // open-drain wire: low if anybody pulls it down
    assign rst_pin_in = ~(ext_low | rst_pin_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    rstpin_ctrl #(.STRETCH_CYCLES(N), .SYNC_STAGES(S)) dut_i (
        .clk          (clk),
        .por          (por),
        .rst_pin_in   (rst_pin_in),
        .wdog_trip    (wdog_trip),
        .sw_rst_req   (sw_rst_req),
        .cfg_wr       (cfg_wr),
        .cfg_bidir_en (cfg_bidir_en),
        .rst_pin_oe   (rst_pin_oe),
        .core_rst     (core_rst),
        .rst_cause    (rst_cause)
    );

    typedef struct {
        int unsigned cyc;
        logic        rst;
        logic        oe;
        int          cause;
        string       tag;
    } exp_item_t;

    exp_item_t   sb_q[$];
    int unsigned cyc = 0;
    int unsigned n_checks = 0;
    int unsigned n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard driver side
    task automatic expect_at(int unsigned at, logic r, logic o, int ca, string tag);
        exp_item_t it;
        it.cyc = at; it.rst = r; it.oe = o; it.cause = ca; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic at_cyc(int unsigned n);
        while (cyc != n) @(negedge clk);
    endtask

    // monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
            exp_item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (it.cyc != cyc) begin
                n_fail++;
                $display("FAIL %s: check for cycle %0d missed at cycle %0d", it.tag, it.cyc, cyc);
            end else if (core_rst !== it.rst || rst_pin_oe !== it.oe ||
                         (it.cause >= 0 && rst_cause !== it.cause[1:0])) begin
                n_fail++;
                $display("FAIL %s @%0d: rst/oe/cause actual %b/%b/%0d expected %b/%b/%0d",
                         it.tag, cyc, core_rst, rst_pin_oe, rst_cause, it.rst, it.oe, it.cause);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        finish_run();
    end

    initial begin
        int unsigned c;
        // R1: power-on
        expect_at(2, 1'b1, 1'b0, 0, "R1");
        expect_at(4, 1'b1, 1'b0, 0, "R1");
        expect_at(4 + N - 1, 1'b1, 1'b0, 0, "R1");
        expect_at(4 + N, 1'b0, 1'b0, 0, "R1");
        at_cyc(4); por = 1'b0;

        // R2 R3 R5: watchdog, enable clear, held 3 cycles
        c = 14;
        expect_at(c, 1'b0, 1'b0, 0, "R10");
        expect_at(c + 1, 1'b1, 1'b0, 2, "R2");
        expect_at(c + 3, 1'b1, 1'b0, 2, "R3");
        expect_at(c + 3 + N - 1, 1'b1, 1'b0, 2, "R5");
        expect_at(c + 3 + N, 1'b0, 1'b0, 2, "R3");
        at_cyc(c); wdog_trip = 1'b1;
        at_cyc(c + 3); wdog_trip = 1'b0;

        // R4 R8: enable set, software reset drives pin, then guard
        c = 30;
        expect_at(c + 2, 1'b1, 1'b1, 3, "R4");
        expect_at(c + 7, 1'b1, 1'b1, 3, "R4");
        expect_at(c + 8, 1'b1, 1'b0, 3, "R8");
        expect_at(c + 10, 1'b1, 1'b0, 3, "R8");
        expect_at(c + 11, 1'b0, 1'b0, 3, "R8");
        at_cyc(c); cfg_wr = 1'b1; cfg_bidir_en = 1'b1;
        at_cyc(c + 1); cfg_wr = 1'b0; sw_rst_req = 1'b1;
        at_cyc(c + 2); sw_rst_req = 1'b0;

        // R6: enable was cleared by the last sequence
        c = 44;
        expect_at(c + 1, 1'b1, 1'b0, 2, "R6");
        expect_at(c + N, 1'b1, 1'b0, 2, "R6");
        expect_at(c + 1 + N, 1'b0, 1'b0, 2, "R6");
        at_cyc(c); wdog_trip = 1'b1;
        at_cyc(c + 1); wdog_trip = 1'b0;

        // R6: write during reset is ignored
        c = 56;
        expect_at(c + 1, 1'b1, 1'b0, 3, "R6");
        expect_at(c + 1 + N, 1'b0, 1'b0, 3, "R6");
        expect_at(c + 10, 1'b1, 1'b0, 2, "R6");
        expect_at(c + 10 + N, 1'b0, 1'b0, 2, "R6");
        at_cyc(c); sw_rst_req = 1'b1;
        at_cyc(c + 1); sw_rst_req = 1'b0;
        at_cyc(c + 2); cfg_wr = 1'b1; cfg_bidir_en = 1'b1;
        at_cyc(c + 3); cfg_wr = 1'b0;
        at_cyc(c + 9); wdog_trip = 1'b1;
        at_cyc(c + 10); wdog_trip = 1'b0;

        // R7 R8: short external pulse, released before guard ends
        c = 80;
        expect_at(c + 2, 1'b0, 1'b0, 2, "R7");
        expect_at(c + 3, 1'b1, 1'b1, 1, "R7");
        expect_at(c + 2 + N, 1'b1, 1'b1, 1, "R7");
        expect_at(c + 3 + N, 1'b1, 1'b0, 1, "R8");
        expect_at(c + 5 + N, 1'b1, 1'b0, 1, "R8");
        expect_at(c + 6 + N, 1'b0, 1'b0, 1, "R8");
        at_cyc(c); ext_low = 1'b1;
        at_cyc(c + 2); ext_low = 1'b0;

        // R8: external held through guard, drive resumes without gap
        c = 100;
        expect_at(c + 3, 1'b1, 1'b1, 1, "R7");
        expect_at(c + 3 + N, 1'b1, 1'b0, 1, "R8");
        expect_at(c + 5 + N, 1'b1, 1'b0, 1, "R8");
        expect_at(c + 6 + N, 1'b1, 1'b1, 1, "R8");
        expect_at(c + 6 + 2*N, 1'b1, 1'b0, 1, "R8");
        expect_at(c + 8 + 2*N, 1'b1, 1'b0, 1, "R8");
        expect_at(c + 9 + 2*N, 1'b0, 1'b0, 1, "R8");
        at_cyc(c); ext_low = 1'b1;
        at_cyc(c + 6 + N); ext_low = 1'b0;

        // R9: priority and hold
        c = 130;
        expect_at(c + 1, 1'b1, 1'b0, 2, "R9");
        expect_at(c + 1 + N, 1'b0, 1'b0, 2, "R9");
        expect_at(c + 11, 1'b1, 1'b1, 1, "R9");
        expect_at(c + 15, 1'b1, 1'b1, 1, "R9");
        expect_at(c + 11 + N, 1'b1, 1'b0, 1, "R8");
        expect_at(c + 11 + N + G, 1'b0, 1'b0, 1, "R9");
        expect_at(c + 26, 1'b0, 1'b0, 1, "R9");
        expect_at(c + 27, 1'b1, 1'b0, 3, "R9");
        expect_at(c + 27 + N, 1'b0, 1'b0, 3, "R9");
        at_cyc(c); wdog_trip = 1'b1; sw_rst_req = 1'b1;
        at_cyc(c + 1); wdog_trip = 1'b0; sw_rst_req = 1'b0;
        at_cyc(c + 8); ext_low = 1'b1;
        at_cyc(c + 10); ext_low = 1'b0; wdog_trip = 1'b1;
        at_cyc(c + 11); wdog_trip = 1'b0;
        at_cyc(c + 26); sw_rst_req = 1'b1;
        at_cyc(c + 27); sw_rst_req = 1'b0;

        at_cyc(c + 27 + N + 3);
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule